// File: doc/BRIEF.md
# DDR SDRAM Command and Bank-State Tracker

This block watches the control inputs of a DDR SDRAM device on every rising clock edge and keeps a model of the device state. For each bank it records whether a row is open and which row that is. It follows the device power condition, holds the contents of the mode register and the extended mode register, and raises a one-cycle error pulse when a command breaks the bank-state rules. It also turns the per-byte data-mask inputs into write byte enables.

The tracker sits beside a memory controller or a device model. It drives nothing onto the memory bus. Every tracked output is registered, so a command sampled on one rising edge shows up on the outputs right after that edge. The byte enables are combinational from the mask inputs.

The command code is formed from chip select plus {ras_n, cas_n, we_n}. Auto-precharge and precharge-all use address bit 10.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: When cs_n is high on an edge, no bank, mode register or error state changes.
- R2: ACTIVE ({ras_n,cas_n,we_n}=011) to an idle bank opens the bank selected by ba and stores addr as that bank's row.
- R3: PRECHARGE (010) with addr[10]=0 closes only bank ba. With addr[10]=1 it closes every bank.
- R4: READ (101) or WRITE (100) to an open bank with addr[10]=1 leaves that bank idle afterwards. With addr[10]=0 the bank stays open with its row unchanged.
- R5: MODE SET (000) with no bank open stores addr in mode_reg when ba=0 and in ext_mode_reg when ba=1. ba=2 or ba=3 changes neither register.
- R6: On an edge in the running state (pwr_state=0) with cke low: if any bank is open, the state becomes active power-down (2). If all banks are idle and the command is REFRESH (001), it becomes self refresh (3). If all banks are idle and the command is anything else, it becomes precharge power-down (1).
- R7: While pwr_state is not 0, every command is ignored. The first edge with cke high returns pwr_state to 0, and the command on that edge is also ignored. Bank states are kept across the whole power-down.
- R8: ACTIVE to an already open bank pulses err for one cycle and leaves that bank's row unchanged.
- R9: READ or WRITE to an idle bank pulses err for one cycle.
- R10: REFRESH or MODE SET while any bank is open pulses err for one cycle and leaves both mode registers unchanged.
- R11: byte_en[i] is the inverse of dm[i]. Byte i covers write data bits 8i+7:8i.
- R12: After reset, all banks are idle, pwr_state is 0, both mode registers are 0 and err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable of the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write enable command bit |
| ba | input | 2 | Bank address, or mode register select |
| addr | input | 13 | Row, column plus auto-precharge bit, or op-code |
| dm | input | 2 | Per-byte write data mask |
| byte_en | output | 2 | Per-byte write enable, inverse of dm |
| bank_open | output | 4 | One bit per bank, set while a row is open |
| bank_row | output | 52 | Row of each bank; bank b uses bits 13b+12:13b |
| pwr_state | output | 2 | 0 running, 1 precharge power-down, 2 active power-down, 3 self refresh |
| mode_reg | output | 13 | Stored mode register op-code |
| ext_mode_reg | output | 13 | Stored extended mode register op-code |
| err | output | 1 | One-cycle protocol violation pulse |

## Verification
The bench builds the tracker with its default parameters: four banks, a 13-bit address with the auto-precharge bit at position 10, and two mask bytes. With four banks, single-bank precharge can be shown to leave three neighbours open. The 13-bit width lets the all-ones row 8191 and op-codes with bit 10 set reach the outputs. With two mask bytes, each byte enable can be checked alone.

// File: rtl/ddr_trk_pkg.sv
// Package: shared command and power-state types for the DDR command tracker.
// Assumes active-low command pins sampled together on one clock edge.
package ddr_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_PPD  = 2'd1,
        PWR_APD  = 2'd2,
        PWR_SREF = 2'd3
    } pwr_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
// Module: turns chip select and the three strobe bits into a command code.
// Assumes chip select high masks the command (decoded as NOP).
module ddr_cmd_decode
    import ddr_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Purpose: map the strobe pattern to a command when selected.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_slot.sv
// Module: open flag and row register of one bank.
// Assumes open_en and close_en are never both set (open wins if they are).
module ddr_bank_slot #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic             close_en,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row
);

    // Purpose: record activation and closure of this bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
            row     <= '0;
        end else if (open_en) begin
            is_open <= 1'b1;
            row     <= row_in;
        end else if (close_en) begin
            is_open <= 1'b0;
        end
    end

endmodule

// File: rtl/ddr_power_fsm.sv
// Module: device power condition driven by cke.
// Assumes any_open reflects bank state before the current edge.
module ddr_power_fsm
    import ddr_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic any_open,
    input  logic ref_cmd,
    output pwr_e state
);

    // Purpose: enter a power-down type on cke low, leave on cke high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PWR_RUN;
        end else if (state == PWR_RUN) begin
            if (!cke) begin
                if (any_open)     state <= PWR_APD;
                else if (ref_cmd) state <= PWR_SREF;
                else              state <= PWR_PPD;
            end
        end else if (cke) begin
            state <= PWR_RUN;
        end
    end

endmodule

// File: rtl/ddr_cmd_tracker.sv
// Module: top of the DDR command and bank-state tracker.
// Tracks open rows per bank, power condition and mode registers, flags
// protocol violations and turns data masks into byte enables.
// Assumes commands execute only in the running state with cke high.
module ddr_cmd_tracker
    import ddr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    parameter int NUM_BYTES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cke,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_BYTES-1:0]        dm,
    output logic [NUM_BYTES-1:0]        byte_en,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] bank_row,
    output logic [1:0]                  pwr_state,
    output logic [ADDR_W-1:0]           mode_reg,
    output logic [ADDR_W-1:0]           ext_mode_reg,
    output logic                        err
);

    localparam int BA_W     = $clog2(NUM_BANKS);
    localparam int MR_SEL   = 0;
    localparam int EMR_SEL  = 1;

    cmd_e cmd;
    pwr_e pwr;
    logic exec;
    logic any_open;
    logic tgt_open;
    logic is_rw;
    logic err_d;
    logic [NUM_BANKS-1:0] open_en;
    logic [NUM_BANKS-1:0] close_en;

    ddr_cmd_decode i_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    ddr_power_fsm i_power (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .any_open (any_open),
        .ref_cmd  (cmd == CMD_REF),
        .state    (pwr)
    );

    // Purpose: qualify commands and derive shared bank conditions.
    always_comb begin
        exec     = (pwr == PWR_RUN) && cke;
        any_open = |bank_open;
        tgt_open = bank_open[ba];
        is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
    end

    // Purpose: per-bank open/close strobes and state registers.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(b));
        assign open_en[b] = exec && (cmd == CMD_ACT) && hit && !bank_open[b];
        assign close_en[b] = exec && (((cmd == CMD_PRE) && (addr[AP_BIT] || hit)) ||
                             (is_rw && addr[AP_BIT] && hit && bank_open[b]));
        ddr_bank_slot #(.ROW_W(ADDR_W)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_en  (open_en[b]),
            .close_en (close_en[b]),
            .row_in   (addr),
            .is_open  (bank_open[b]),
            .row      (bank_row[b*ADDR_W +: ADDR_W])
        );
    end

    // Purpose: detect rule violations of the current command.
    always_comb begin
        err_d = exec && (((cmd == CMD_ACT) && tgt_open) ||
                         (is_rw && !tgt_open) ||
                         (((cmd == CMD_REF) || (cmd == CMD_MRS)) && any_open));
    end

    // Purpose: register the error pulse and the mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err          <= 1'b0;
            mode_reg     <= '0;
            ext_mode_reg <= '0;
        end else begin
            err <= err_d;
            if (exec && (cmd == CMD_MRS) && !any_open) begin
                if (ba == BA_W'(MR_SEL))  mode_reg     <= addr;
                if (ba == BA_W'(EMR_SEL)) ext_mode_reg <= addr;
            end
        end
    end

    // Purpose: byte enables from data masks and power state out.
    always_comb begin
        byte_en   = ~dm;
        pwr_state = pwr;
    end

endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
// Module: protocol checker bound to the tracker; observes ports only.
// Assumes the same parameter values as the tracker it watches.
module ddr_cmd_tracker_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cke,
    input logic                         cs_n,
    input logic                         ras_n,
    input logic                         cas_n,
    input logic                         we_n,
    input logic [$clog2(NUM_BANKS)-1:0] ba,
    input logic [ADDR_W-1:0]            addr,
    input logic [NUM_BANKS-1:0]         bank_open,
    input logic [1:0]                   pwr_state,
    input logic [ADDR_W-1:0]            mode_reg,
    input logic [ADDR_W-1:0]            ext_mode_reg,
    input logic                         err
);

    logic running;
    assign running = (pwr_state == 2'd0) && cke;

    // R1: deselected edges change nothing
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(bank_open) && $stable(mode_reg) && $stable(ext_mode_reg) && !err));

    // R3: precharge with addr[10] high closes every bank
    a_r3_close_all: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cs_n && {ras_n, cas_n, we_n} == 3'b010 && addr[AP_BIT]) |=> (bank_open == '0));

    // R6: cke low with a row open enters active power-down
    a_r6_active_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && !cke && |bank_open) |=> (pwr_state == 2'd2));

    // R7: power-down with cke low keeps everything frozen
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0 && !cke) |=> ($stable(bank_open) && $stable(pwr_state) && !err));

    // R8: activating an open bank raises the error pulse
    a_r8_double_act: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cs_n && {ras_n, cas_n, we_n} == 3'b011 && bank_open[ba]) |=> err);

    // R9: access to an idle bank raises the error pulse
    a_r9_idle_access: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cs_n && {ras_n, cas_n} == 2'b10 && !bank_open[ba]) |=> err);

endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .AP_BIT    (AP_BIT)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .ba           (ba),
    .addr         (addr),
    .bank_open    (bank_open),
    .pwr_state    (pwr_state),
    .mode_reg     (mode_reg),
    .ext_mode_reg (ext_mode_reg),
    .err          (err)
);

// File: tb/test_ddr_cmd_tracker.sv
`timescale 1ns/1ps
module test_ddr_cmd_tracker;

    localparam int NB = 4;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1;
    logic          cs_n = 1'b1;
    logic          ras_n = 1'b1;
    logic          cas_n = 1'b1;
    logic          we_n = 1'b1;
    logic [1:0]    ba = '0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    dm = '0;
    logic [1:0]    byte_en;
    logic [NB-1:0] bank_open;
    logic [NB*AW-1:0] bank_row;
    logic [1:0]    pwr_state;
    logic [AW-1:0] mode_reg;
    logic [AW-1:0] ext_mode_reg;
    logic          err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ddr_cmd_tracker i_ddr_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dm(dm),
        .byte_en(byte_en), .bank_open(bank_open), .bank_row(bank_row),
        .pwr_state(pwr_state), .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg),
        .err(err)
    );

    typedef struct {
        logic [NB-1:0]    open;
        logic [NB*AW-1:0] rows;
        logic [1:0]       pwr;
        logic [AW-1:0]    mr;
        logic [AW-1:0]    emr;
        logic             err;
        string            req;
    } exp_t;

    exp_t sb[$];

    // reference model state
    logic [NB-1:0]    m_open = '0;
    logic [NB*AW-1:0] m_rows = '0;
    logic [1:0]       m_pwr = 2'd0;
    logic [AW-1:0]    m_mr = '0;
    logic [AW-1:0]    m_emr = '0;

    // driver: apply one edge of stimulus, update model, push expectation
    task automatic step(input logic k, input logic cs, input logic [2:0] c,
                        input logic [1:0] b, input logic [AW-1:0] a, input string req);
        logic e;
        logic run;
        exp_t x;
        @(negedge clk);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
        @(posedge clk);
        #1;
        e = 1'b0;
        run = (m_pwr == 2'd0) && k;
        if (m_pwr == 2'd0) begin
            if (!k) begin
                if (|m_open)                    m_pwr = 2'd2;
                else if (!cs && c == 3'b001)    m_pwr = 2'd3;
                else                            m_pwr = 2'd1;
            end
        end else if (k) begin
            m_pwr = 2'd0;
        end
        if (run && !cs) begin
            case (c)
                3'b011: if (m_open[b]) e = 1'b1;
                        else begin m_open[b] = 1'b1; m_rows[b*AW +: AW] = a; end
                3'b101, 3'b100: if (!m_open[b]) e = 1'b1;
                                else if (a[10]) m_open[b] = 1'b0;
                3'b010: if (a[10]) m_open = '0; else m_open[b] = 1'b0;
                3'b001: if (|m_open) e = 1'b1;
                3'b000: if (|m_open) e = 1'b1;
                        else if (b == 2'd0) m_mr = a;
                        else if (b == 2'd1) m_emr = a;
                default: ;
            endcase
        end
        x.open = m_open; x.rows = m_rows; x.pwr = m_pwr;
        x.mr = m_mr; x.emr = m_emr; x.err = e; x.req = req;
        sb.push_back(x);
    endtask

    // monitor: compare registered outputs mid-cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t x;
            logic ok;
            x = sb.pop_front();
            ok = (bank_open === x.open) && (pwr_state === x.pwr) &&
                 (mode_reg === x.mr) && (ext_mode_reg === x.emr) && (err === x.err);
            for (int b = 0; b < NB; b++)
                if (x.open[b] && bank_row[b*AW +: AW] !== x.rows[b*AW +: AW]) ok = 1'b0;
            checks++;
            if (!ok) begin
                failures++;
                $display("FAIL %s: got open=%b pwr=%0d mr=%h emr=%h err=%b rows=%h exp open=%b pwr=%0d mr=%h emr=%h err=%b rows=%h",
                         x.req, bank_open, pwr_state, mode_reg, ext_mode_reg, err, bank_row,
                         x.open, x.pwr, x.mr, x.emr, x.err, x.rows);
            end
        end
    end

    task automatic check_be(input logic [1:0] m);
        @(negedge clk);
        dm = m;
        #1;
        checks++;
        if (byte_en !== ~m) begin
            failures++;
            $display("FAIL R11: byte_en=%b expected %b", byte_en, ~m);
        end
    endtask

    localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                           PRE = 3'b010, REF = 3'b001, MRS = 3'b000, BST = 3'b110;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, NOP, 0, 0, "R12");
        step(1, 1, ACT, 0, 13'd5, "R1");
        step(1, 0, ACT, 0, 13'h1FFF, "R2");
        step(1, 0, ACT, 2, 13'h0123, "R2");
        step(1, 0, ACT, 0, 13'h0007, "R8");
        step(1, 0, MRS, 0, 13'h0055, "R10");
        step(1, 0, REF, 0, 0, "R10");
        step(1, 0, RD, 1, 0, "R9");
        step(1, 0, WR, 3, 0, "R9");
        step(1, 0, WR, 2, 13'h0010, "R4");
        step(1, 0, RD, 2, 13'h0400, "R4");
        step(1, 0, ACT, 1, 13'h0AAA, "R2");
        step(1, 0, ACT, 3, 13'h0333, "R2");
        step(1, 0, PRE, 1, 0, "R3");
        step(1, 0, BST, 0, 0, "R1");
        step(1, 0, PRE, 2, 13'h0400, "R3");
        step(1, 0, MRS, 0, 13'h0123, "R5");
        step(1, 0, MRS, 1, 13'h0442, "R5");
        step(1, 0, MRS, 2, 13'h1555, "R5");
        step(1, 0, MRS, 3, 13'h0AAA, "R5");
        step(0, 0, NOP, 0, 0, "R6");
        step(0, 0, ACT, 0, 13'h0011, "R7");
        step(1, 0, ACT, 1, 13'h0022, "R7");
        step(1, 0, NOP, 0, 0, "R7");
        step(0, 0, REF, 0, 0, "R6");
        step(0, 0, MRS, 0, 13'h0FFF, "R7");
        step(1, 0, NOP, 0, 0, "R7");
        step(1, 0, ACT, 3, 13'h0099, "R2");
        step(0, 0, REF, 0, 0, "R6");
        step(0, 0, PRE, 0, 13'h0400, "R7");
        step(1, 0, NOP, 0, 0, "R7");
        step(1, 0, RD, 3, 0, "R4");
        check_be(2'b01);
        check_be(2'b10);
        check_be(2'b11);
        check_be(2'b00);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule